// File: doc/BRIEF.md
# Packed Instruction Issue Sequencer

This block sits between instruction fetch and decode in a small in-order pipeline. It takes one 32-bit fetched word at a time over a ready/valid handshake and gives decode at most one instruction per clock. An ordinary word passes through unchanged. A packed word holds five 5-bit index fields. The block expands it into a run of instructions read from a 32-entry instruction store, one per cycle, in field order. Index 0 marks an empty field and takes no cycle. While a run is in progress, fetch is held off.

Up to two index fields can carry parameters instead of instructions. A parameter aimed at an ordinary instruction picks a 16-bit value from a 32-entry immediate table. A parameter aimed at a branch is a 5-bit displacement that is placed in the immediate field directly. Each store entry also holds a default immediate, which is used when no parameter targets it. When a branch resolves as taken, the remaining fields are cancelled. Two write ports load the instruction store and the immediate table while the block is idle.

Two states are used. `ST_IDLE` accepts words; if the word is packed, it also issues the first live field in the same cycle. `ST_EXPAND` issues the remaining live fields. The transitions are: `ST_IDLE -> ST_EXPAND` when a packed word has more than one live field; `ST_EXPAND -> ST_EXPAND` while live fields remain; `ST_EXPAND -> ST_IDLE` on the last live field or on a taken branch; `ST_IDLE -> ST_IDLE` otherwise.

Top module: `pis_top`

## Requirements
- R1: A word with bits [31:30] not equal to 2'b11, or with bits [29:28] equal to 2'b11, is ordinary. It appears unchanged on `out_insn`, with `out_valid` high, in the cycle after it is accepted. It is issued exactly once, and `in_ready` stays high.
- R2: A packed word has bits [31:30]=2'b11 and a mode in bits [29:28] other than 2'b11. Its index fields are, in order, [25:21], [20:16], [15:11], [10:6] and [4:0]. Live fields issue one per cycle in that order, starting in the cycle after acceptance.
- R3: An index field equal to 0 issues nothing and takes no cycle. A packed word whose fields are all zero produces no output.
- R4: After a packed word with more than one live field is accepted, `in_ready` is low. It returns high in the cycle in which the last expanded instruction appears on the output.
- R5: Mode 2'b00 uses all five fields as instructions. Mode 2'b01 uses the first four fields as instructions and field [4:0] as one parameter. Mode 2'b10 uses the first three fields as instructions, field [10:6] as the first parameter and field [4:0] as the second. Fields beyond the instruction count never issue.
- R6: Bits [27:26] select the parameter targets. In mode 2'b01 they give the position (0 = first) that receives the parameter. In mode 2'b10, 00 targets the first and second positions, 01 targets the first and third, 10 targets the second and third, and 11 behaves as 01.
- R7: An instruction targeted by a parameter, whose store entry is not marked as a branch, is issued with bits [15:0] replaced by the immediate-table entry that the parameter indexes. Bits [31:16] come from the store.
- R8: An instruction that no parameter targets is issued exactly as stored; its bits [15:0] are its default immediate.
- R9: A parameter targeting a branch entry is placed in bits [15:0] as a 16-bit extension of its 5 bits. The first parameter is always sign-extended. The second is sign-extended when word bit [5] is 1 and zero-extended when it is 0.
- R10: While `br_taken` is high, no instruction is issued in the following cycle, any fields not yet issued are cancelled, `in_ready` is high in the following cycle, and a word offered in the same cycle is discarded.
- R11: A write on either load port while idle changes what later expansions issue from that entry.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched word valid |
| in_ready | output | 1 | Sequencer can take a word |
| in_word | input | 32 | Fetched word |
| br_taken | input | 1 | Taken-branch flush |
| out_valid | output | 1 | Instruction to decode is valid |
| out_insn | output | 32 | Instruction to decode |
| irf_we | input | 1 | Instruction store write enable |
| irf_waddr | input | 5 | Instruction store write index |
| irf_wdata | input | 32 | Instruction store write word, low IMM_W bits are the default immediate |
| irf_wbr | input | 1 | Marks the written entry as a branch |
| imm_we | input | 1 | Immediate table write enable |
| imm_waddr | input | 5 | Immediate table write index |
| imm_wdata | input | IMM_W | Immediate table write value |

## Verification
The bench builds the block with its default immediate width of 16 bits and full 32-entry tables. With that width, every 5-bit parameter value, including the top index 31, is reachable. Because 16 bits is wider than a parameter, sign extension and zero extension of a branch displacement produce different upper bits, so the two cases can be told apart. With all five fields addressable, the full-length run and the three-instruction mode with parameters on the first and third positions can both be exercised.

// File: rtl/pis_pkg.sv
package pis_pkg;
    localparam int WORD_W = 32;
    localparam int OPC_W  = 6;
    localparam int IDX_W  = 5;
    localparam int NSLOT  = 5;
    localparam int POS_W  = $clog2(NSLOT);

    typedef enum logic [0:0] {ST_IDLE, ST_EXPAND} state_e;

    typedef struct packed {
        logic                             is_pk;
        logic [NSLOT-1:0]                 mask;
        logic [NSLOT-1:0][IDX_W-1:0]      slot;
        logic                             pa_on;
        logic [POS_W-1:0]                 pa_tgt;
        logic                             pb_on;
        logic [POS_W-1:0]                 pb_tgt;
        logic                             pb_sext;
    } dec_t;
endpackage

// File: rtl/pis_decode.sv
module pis_decode
    import pis_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    localparam int FIELD_TOP = WORD_W - OPC_W - 1;

    logic [1:0]       mode;
    logic [1:0]       sel;
    logic [POS_W:0]   ninst;
    logic             pk;

    assign mode = word[WORD_W-3 -: 2];
    assign sel  = word[WORD_W-5 -: 2];
    assign pk   = (word[WORD_W-1 -: 2] == 2'b11) && (mode != 2'b11);

    always_comb begin
        unique case (mode)
            2'b00:   ninst = (POS_W+1)'(NSLOT);
            2'b01:   ninst = (POS_W+1)'(NSLOT - 1);
            default: ninst = (POS_W+1)'(NSLOT - 2);
        endcase
    end

    genvar k;
    generate
        for (k = 0; k < NSLOT; k++) begin : g_slot
            if (k < NSLOT - 1) begin : g_hi
                assign dec.slot[k] = word[FIELD_TOP - k*IDX_W -: IDX_W];
            end else begin : g_lo
                assign dec.slot[k] = word[IDX_W-1:0];
            end
            assign dec.mask[k] = pk && ((POS_W+1)'(k) < ninst) && (dec.slot[k] != '0);
        end
    endgenerate

    assign dec.is_pk   = pk;
    assign dec.pa_on   = pk && (mode == 2'b10);
    assign dec.pb_on   = pk && ((mode == 2'b01) || (mode == 2'b10));
    assign dec.pa_tgt  = (sel == 2'b10) ? POS_W'(1) : POS_W'(0);
    assign dec.pb_tgt  = (mode == 2'b01) ? POS_W'(sel)
                       : ((sel == 2'b00) ? POS_W'(1) : POS_W'(2));
    assign dec.pb_sext = word[IDX_W];
endmodule

// File: rtl/pis_pick.sv
module pis_pick #(
    parameter int N = 5,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [PW-1:0] pos,
    output logic          any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_chain
            assign grant[i]  = req[i] && !seen[i];
            assign seen[i+1] = seen[i] || req[i];
        end
    endgenerate

    assign any = seen[N];

    always_comb begin
        pos = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (req[j]) pos = PW'(j);
        end
    end
endmodule

// File: rtl/pis_store.sv
module pis_store #(
    parameter int IDX_W  = 5,
    parameter int WORD_W = 32,
    parameter int IMM_W  = 16,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              irf_we,
    input  logic [IDX_W-1:0]  irf_waddr,
    input  logic [WORD_W-1:0] irf_wdata,
    input  logic              irf_wbr,
    input  logic              imm_we,
    input  logic [IDX_W-1:0]  imm_waddr,
    input  logic [IMM_W-1:0]  imm_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_br,
    input  logic [IDX_W-1:0]  imm_idx,
    output logic [IMM_W-1:0]  imm_val
);
    logic [WORD_W-1:0] insn_mem [DEPTH];
    logic              br_mem   [DEPTH];
    logic [IMM_W-1:0]  imm_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (irf_we) begin
            insn_mem[irf_waddr] <= irf_wdata;
            br_mem[irf_waddr]   <= irf_wbr;
        end
        if (imm_we) begin
            imm_mem[imm_waddr] <= imm_wdata;
        end
    end

    assign rd_word = insn_mem[rd_idx];
    assign rd_br   = br_mem[rd_idx];
    assign imm_val = imm_mem[imm_idx];
endmodule

// File: rtl/pis_top.sv
module pis_top
    import pis_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              br_taken,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_insn,
    input  logic              irf_we,
    input  logic [IDX_W-1:0]  irf_waddr,
    input  logic [WORD_W-1:0] irf_wdata,
    input  logic              irf_wbr,
    input  logic              imm_we,
    input  logic [IDX_W-1:0]  imm_waddr,
    input  logic [IMM_W-1:0]  imm_wdata
);
    localparam int EXT_W = IMM_W - IDX_W;

    state_e            state_q, state_d;
    logic [WORD_W-1:0] hold_q;
    logic [NSLOT-1:0]  pend_q;
    logic [WORD_W-1:0] src;
    dec_t              dec;
    logic [NSLOT-1:0]  live, grant, rem;
    logic [POS_W-1:0]  pos;
    logic              any, accept, issue_pk;
    logic              use_a, use_b, psx;
    logic [IDX_W-1:0]  pval;
    logic [WORD_W-1:0] rd_word;
    logic              rd_br;
    logic [IMM_W-1:0]  imm_val, disp, new_imm;
    logic              out_valid_q;
    logic [WORD_W-1:0] out_insn_q;

    assign src      = (state_q == ST_IDLE) ? in_word : hold_q;
    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_ready && in_valid && !br_taken;

    pis_decode u_dec (.word(src), .dec(dec));

    assign live = (state_q == ST_IDLE) ? dec.mask : pend_q;

    pis_pick #(.N(NSLOT)) u_pick (.req(live), .grant(grant), .pos(pos), .any(any));

    assign rem      = live & ~grant;
    assign issue_pk = dec.is_pk && any && !br_taken && ((state_q == ST_EXPAND) || accept);

    assign use_b = dec.pb_on && (dec.pb_tgt == pos);
    assign use_a = dec.pa_on && (dec.pa_tgt == pos) && !use_b;
    assign pval  = use_b ? dec.slot[NSLOT-1] : dec.slot[NSLOT-2];
    assign psx   = use_b ? dec.pb_sext : 1'b1;
    assign disp  = {{EXT_W{psx & pval[IDX_W-1]}}, pval};

    pis_store #(.IDX_W(IDX_W), .WORD_W(WORD_W), .IMM_W(IMM_W)) u_store (
        .clk(clk),
        .irf_we(irf_we), .irf_waddr(irf_waddr), .irf_wdata(irf_wdata), .irf_wbr(irf_wbr),
        .imm_we(imm_we), .imm_waddr(imm_waddr), .imm_wdata(imm_wdata),
        .rd_idx(dec.slot[pos]), .rd_word(rd_word), .rd_br(rd_br),
        .imm_idx(pval), .imm_val(imm_val)
    );

    assign new_imm = (use_a || use_b) ? (rd_br ? disp : imm_val) : rd_word[IMM_W-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && dec.is_pk && (rem != '0)) state_d = ST_EXPAND;
            ST_EXPAND: if (br_taken || (rem == '0))            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_insn_q  <= '0;
            hold_q      <= '0;
            pend_q      <= '0;
        end else begin
            pend_q <= rem;
            if (accept) hold_q <= in_word;
            if (br_taken) begin
                out_valid_q <= 1'b0;
            end else if (accept && !dec.is_pk) begin
                out_valid_q <= 1'b1;
                out_insn_q  <= in_word;
            end else if (issue_pk) begin
                out_valid_q <= 1'b1;
                out_insn_q  <= {rd_word[WORD_W-1:IMM_W], new_imm};
            end else begin
                out_valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_insn  = out_insn_q;

    AST_ORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec.is_pk) |=> (out_valid && out_insn == $past(in_word))); // R1
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2
    AST_EXPAND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPAND) |-> (pend_q != '0)); // R3
    AST_PACKED_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.is_pk && ($countones(dec.mask) > 1)) |=> !in_ready); // R4
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (!out_valid && in_ready)); // R10
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irf_we || imm_we) |-> in_ready); // R11
endmodule

// File: tb/pis_top_tb.sv
module pis_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        br_taken = 1'b0;
    logic        out_valid;
    logic [31:0] out_insn;
    logic        irf_we = 1'b0;
    logic [4:0]  irf_waddr = '0;
    logic [31:0] irf_wdata = '0;
    logic        irf_wbr = 1'b0;
    logic        imm_we = 1'b0;
    logic [4:0]  imm_waddr = '0;
    logic [15:0] imm_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] got [8];
    int          ngot;
    logic        rdy [9];

    always #5 clk = ~clk;

    pis_top u_dut (.*);

    function automatic logic [31:0] ent(int i);
        return {6'h08, 5'(i), 5'd0, 16'h0100 + 16'(i)};
    endfunction
    function automatic logic [15:0] up(int i);
        logic [31:0] e;
        e = ent(i);
        return e[31:16];
    endfunction
    function automatic logic [15:0] immv(int j);
        return 16'hB000 + 16'(j);
    endfunction
    function automatic logic [31:0] pk(logic [5:0] op, logic [4:0] a, logic [4:0] b,
                                       logic [4:0] c, logic [4:0] d, logic [4:0] e, logic f);
        return {op, a, b, c, d, f, e};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_irf(int i, logic [31:0] w, logic br);
        @(negedge clk);
        irf_we = 1'b1; irf_waddr = 5'(i); irf_wdata = w; irf_wbr = br;
        @(negedge clk);
        irf_we = 1'b0;
    endtask

    task automatic wr_imm(int j, logic [15:0] v);
        @(negedge clk);
        imm_we = 1'b1; imm_waddr = 5'(j); imm_wdata = v;
        @(negedge clk);
        imm_we = 1'b0;
    endtask

    task automatic run(logic [31:0] w, int flush_at);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; br_taken = (flush_at == 0);
        ngot = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            rdy[c] = in_ready;
            if (out_valid) begin
                if (ngot < 8) got[ngot] = out_insn;
                ngot++;
            end
            br_taken = (flush_at == c);
        end
        br_taken = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 out_valid", 32'(out_valid), 32'd0);
        chk("R12 in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_ordinary;
        run(32'h1234_5678, -1);
        chk("R1 count", ngot, 1);
        chk("R1 word", got[0], 32'h1234_5678);
        chk("R1 ready", 32'(rdy[1]), 32'd1);
        run(32'hF0AB_CDEF, -1);
        chk("R1 mode11 count", ngot, 1);
        chk("R1 mode11 word", got[0], 32'hF0AB_CDEF);
    endtask

    task automatic t_five;
        run(pk(6'h30, 5'd3, 5'd0, 5'd5, 5'd1, 5'd9, 1'b0), -1);
        chk("R3 count", ngot, 4);
        chk("R2 first", got[0], ent(3));
        chk("R2 second", got[1], ent(5));
        chk("R2 third", got[2], ent(1));
        chk("R8 fourth", got[3], ent(9));
        chk("R4 stall", 32'(rdy[1]), 32'd0);
        chk("R4 stall late", 32'(rdy[3]), 32'd0);
        chk("R4 release", 32'(rdy[4]), 32'd1);
    endtask

    task automatic t_allnop;
        run(pk(6'h30, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0), -1);
        chk("R3 empty count", ngot, 0);
        chk("R3 empty ready", 32'(rdy[1]), 32'd1);
    endtask

    task automatic t_onep;
        run(pk(6'h36, 5'd1, 5'd2, 5'd3, 5'd4, 5'd9, 1'b0), -1);
        chk("R5 one-param count", ngot, 4);
        chk("R8 one-param p1", got[0], ent(1));
        chk("R8 one-param p2", got[1], ent(2));
        chk("R6 R7 one-param p3", got[2], {up(3), immv(9)});
        chk("R5 one-param p4", got[3], ent(4));
    endtask

    task automatic t_first_third;
        run(pk(6'h39, 5'd2, 5'd4, 5'd12, 5'd6, 5'b11101, 1'b1), -1);
        chk("R5 two-param count", ngot, 3);
        chk("R7 first gets table", got[0], {up(2), immv(6)});
        chk("R8 middle default", got[1], ent(4));
        chk("R9 branch sign", got[2], {up(12), 16'hFFFD});
        run(pk(6'h39, 5'd2, 5'd4, 5'd12, 5'd6, 5'b11101, 1'b0), -1);
        chk("R9 branch zero", got[2], {up(12), 16'h001D});
        run(pk(6'h3B, 5'd2, 5'd4, 5'd12, 5'd6, 5'b11101, 1'b1), -1);
        chk("R6 sel11 alias", got[0], {up(2), immv(6)});
    endtask

    task automatic t_other_targets;
        run(pk(6'h3A, 5'd7, 5'd3, 5'd12, 5'b10010, 5'b00100, 1'b0), -1);
        chk("R6 second-third count", ngot, 3);
        chk("R8 untargeted branch", got[0], ent(7));
        chk("R6 R7 second", got[1], {up(3), immv(18)});
        chk("R9 third zero", got[2], {up(12), 16'h0004});
        run(pk(6'h38, 5'd7, 5'd3, 5'd0, 5'b10000, 5'd9, 1'b1), -1);
        chk("R3 first-second count", ngot, 2);
        chk("R9 first param sign", got[0], {up(7), 16'hFFF0});
        chk("R6 R7 second param", got[1], {up(3), immv(9)});
    endtask

    task automatic t_flush;
        run(pk(6'h30, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 1'b0), 1);
        chk("R10 mid count", ngot, 1);
        chk("R10 mid first", got[0], ent(1));
        chk("R10 mid ready", 32'(rdy[2]), 32'd1);
        run(pk(6'h30, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 1'b0), 0);
        chk("R10 drop count", ngot, 0);
    endtask

    task automatic t_write;
        wr_imm(9, 16'h5A5A);
        wr_irf(1, 32'hDEAD_0042, 1'b0);
        run(pk(6'h36, 5'd1, 5'd2, 5'd3, 5'd4, 5'd9, 1'b0), -1);
        chk("R11 store rewrite", got[0], 32'hDEAD_0042);
        chk("R11 table rewrite", got[2], {up(3), 16'h5A5A});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 1; i < 32; i++) wr_irf(i, ent(i), (i == 7) || (i == 12));
        for (int j = 0; j < 32; j++) wr_imm(j, immv(j));
        t_ordinary();
        t_five();
        t_allnop();
        t_onep();
        t_first_third();
        t_other_targets();
        t_flush();
        t_write();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule